// File: doc/BRIEF.md
# Serial Protection-Table Wipe Sequencer

This block sits behind a four-wire serial slave port (clock idles low, data sampled on the rising clock edge). It watches for one fixed 32-bit command and resets a 64-byte protection table to all-ones. That value marks every sector as guarded. While select is low, incoming bits are gathered eight at a time, most significant bit first. Each completed byte is compared with the expected byte for its position. The wipe is launched only if exactly 32 matching bits were seen and select then returns high.

Serial pins are brought into the system clock domain through a synchronizer. After launch, a counter keeps `busy` high for a fixed number of system clocks. On the final edge of that window every table byte becomes FFh. A simple program port can only clear bits, so a byte can be rewritten freely only after a wipe. A lock input from the protection arbiter refuses the wipe and blocks programming.

Top module: `prot_wipe_seq`

## Requirements
- R1: After reset `busy` is 0 and every one of the 64 table bytes reads 00h.
- R2: The byte sequence 3Dh, 2Ah, 7Fh, CFh, sent MSB first on `si`, sampled on rising `sclk` while `cs_n` is low, followed by `cs_n` going high, starts a wipe, and `busy` rises within 20 clocks of the release.
- R3: Once raised, `busy` stays high for exactly ERASE_CYCLES system clocks.
- R4: In the first cycle `busy` is low again, all 64 bytes read FFh.
- R5: Holding `cs_n` low after the 32nd bit starts nothing; the wipe begins only on release.
- R6: A byte that differs from the expected one at its position cancels the command.
- R7: Any bit after the 32nd (33 or more bits) cancels the command.
- R8: Releasing `cs_n` after fewer than 32 bits, mid-byte or on a byte boundary, cancels the command.
- R9: A complete command whose release lands while `busy` is high is ignored: the running wipe is neither extended nor repeated.
- R10: If `ro_lock` is high when a valid release is seen, no wipe starts.
- R11: A program strobe sets the addressed byte to old AND `prog_data`, so it can only clear bits; the strobe has no effect while `busy` or `ro_lock` is high.
- R12: `rd_data` shows the byte selected by `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles low, asynchronous |
| si | input | 1 | Serial data in, MSB first |
| ro_lock | input | 1 | Table is read-only; wipe and programming refused |
| prog_en | input | 1 | One-cycle program strobe |
| prog_addr | input | 6 | Byte index to program |
| prog_data | input | 8 | Value ANDed into the addressed byte |
| rd_addr | input | 6 | Byte index to read |
| rd_data | output | 8 | Addressed table byte |
| busy | output | 1 | Wipe in progress |

## Verification
The in-line properties cover the cycle-level rules. A launch pulse lasts one cycle. The bit counter never passes 32. A locked release never raises `busy`. A started window begins at its full count and cannot be shortened or restarted. Programming never sets a bit, and a blocked strobe leaves the table intact. The table reads FFh when `busy` falls. The directed scenarios are needed to show that exactly the right serial patterns launch a wipe. This includes wrong bytes, short and long frames, and a held select. They also show that the busy window has the exact length and that a command sent during a wipe changes nothing.

// File: rtl/prot_wipe_pkg.sv
package prot_wipe_pkg;

    localparam int CMD_BYTES = 4;
    localparam int CMD_BITS  = CMD_BYTES * 8;

    // expected command byte at each position of the frame
    function automatic logic [7:0] cmd_byte(input logic [1:0] pos);
        logic [7:0] b;
        case (pos)
            2'd0:    b = 8'h3D;
            2'd1:    b = 8'h2A;
            2'd2:    b = 8'h7F;
            default: b = 8'hCF;
        endcase
        return b;
    endfunction

    typedef enum logic {
        WS_IDLE,
        WS_WIPE
    } wipe_state_e;

endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/pw_cmd_decode.sv
module pw_cmd_decode
    import prot_wipe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sclk_s,
    input  logic si_s,
    output logic launch_o
);

    typedef struct packed {
        logic       sclk_prev;
        logic       cs_prev;
        logic [6:0] shift;
        logic [5:0] bits;
        logic       fail;
        logic       launch;
    } dec_t;

    dec_t dec_d, dec_q;

    logic sclk_rise;
    logic cs_rise;
    logic [7:0] byte_done;

    assign sclk_rise = sclk_s && !dec_q.sclk_prev;
    assign cs_rise   = cs_n_s && !dec_q.cs_prev;
    assign byte_done = {dec_q.shift, si_s};

    always_comb begin
        dec_d           = dec_q;
        dec_d.launch    = 1'b0;
        dec_d.sclk_prev = sclk_s;
        dec_d.cs_prev   = cs_n_s;
        if (cs_n_s) begin
            // frame closed: decide, then clear for the next frame
            if (cs_rise) begin
                dec_d.launch = (dec_q.bits == 6'(CMD_BITS)) && !dec_q.fail;
            end
            dec_d.bits  = '0;
            dec_d.fail  = 1'b0;
            dec_d.shift = '0;
        end else if (sclk_rise) begin
            if (dec_q.bits >= 6'(CMD_BITS)) begin
                dec_d.fail = 1'b1;                  // surplus bit
            end else begin
                dec_d.shift = {dec_q.shift[5:0], si_s};
                dec_d.bits  = dec_q.bits + 6'd1;
                if (dec_q.bits[2:0] == 3'd7 &&
                    byte_done != cmd_byte(dec_q.bits[4:3])) begin
                    dec_d.fail = 1'b1;              // wrong byte
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q           <= '0;
            dec_q.cs_prev   <= 1'b1;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign launch_o = dec_q.launch;

    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.launch |=> !dec_q.launch);                         // R2

    AST_BITS_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.bits <= 6'(CMD_BITS));                             // R7

    AST_LAUNCH_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.launch |-> $past(cs_n_s));                         // R5

endmodule

// File: rtl/pw_wipe_ctrl.sv
module pw_wipe_ctrl
    import prot_wipe_pkg::*;
#(
    parameter int ERASE_CYCLES = 500,
    localparam int CW = $clog2(ERASE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic lock_i,
    output logic busy_o,
    output logic wipe_o
);

    typedef struct packed {
        wipe_state_e state;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            WS_IDLE: begin
                if (launch_i && !lock_i) begin
                    ctl_d.state = WS_WIPE;
                    ctl_d.cnt   = CW'(ERASE_CYCLES - 1);
                end
            end
            default: begin
                if (ctl_q.cnt == '0) ctl_d.state = WS_IDLE;
                else                 ctl_d.cnt   = ctl_q.cnt - CW'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= WS_IDLE;
            ctl_q.cnt   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.state == WS_WIPE);
    assign wipe_o = busy_o && (ctl_q.cnt == '0);

    AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && launch_i && lock_i) |=> !busy_o);            // R10

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.cnt != '0) |=> busy_o);                 // R3

    AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (ctl_q.cnt == CW'(ERASE_CYCLES - 1))); // R3

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && launch_i && ctl_q.cnt != '0)
            |=> (ctl_q.cnt == CW'($past(ctl_q.cnt) - CW'(1))));  // R9

endmodule

// File: rtl/pw_table.sv
module pw_table #(
    parameter int NUM_BYTES = 64,
    localparam int AW = $clog2(NUM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe_i,
    input  logic          prog_en_i,
    input  logic          prog_block_i,
    input  logic [AW-1:0] prog_addr_i,
    input  logic [7:0]    prog_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o
);

    logic [NUM_BYTES-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wipe_i) begin
            mem_d = {NUM_BYTES{8'hFF}};
        end else if (prog_en_i && !prog_block_i &&
                     int'(prog_addr_i) < NUM_BYTES) begin
            mem_d[prog_addr_i] = mem_q[prog_addr_i] & prog_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data_o = (int'(rd_addr_i) < NUM_BYTES) ? mem_q[rd_addr_i] : 8'h00;

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe_i |=> ((mem_q[$past(prog_addr_i)] &
                      ~$past(mem_q[prog_addr_i])) == 8'h00));    // R11

    AST_BLOCKED_PROG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_block_i && !wipe_i) |=> $stable(mem_q));           // R11

    AST_WIPE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> (mem_q == {NUM_BYTES{8'hFF}}));               // R4

endmodule

// File: rtl/prot_wipe_seq.sv
module prot_wipe_seq #(
    parameter int NUM_BYTES    = 64,
    parameter int ERASE_CYCLES = 500,
    parameter int SYNC_STAGES  = 2,
    localparam int AW = $clog2(NUM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          si,
    input  logic          ro_lock,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);

    logic [2:0] pins_s;
    logic       launch;
    logic       wipe;
    logic       prog_block;

    pw_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, si}),
        .sync_o  (pins_s)
    );

    pw_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .si_s     (pins_s[0]),
        .launch_o (launch)
    );

    pw_wipe_ctrl #(
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .lock_i   (ro_lock),
        .busy_o   (busy),
        .wipe_o   (wipe)
    );

    assign prog_block = busy || ro_lock;

    pw_table #(
        .NUM_BYTES (NUM_BYTES)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .wipe_i       (wipe),
        .prog_en_i    (prog_en),
        .prog_block_i (prog_block),
        .prog_addr_i  (prog_addr),
        .prog_data_i  (prog_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data)
    );

    AST_ERASED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rd_data == 8'hFF));                     // R4

endmodule

// File: tb/prot_wipe_seq_test.sv
module prot_wipe_seq_test;

    localparam int ERASE = 600;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       si = 1'b0;
    logic       ro_lock = 1'b0;
    logic       prog_en = 1'b0;
    logic [5:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int rise_cyc = 0;
    int fall_cyc = 0;
    logic busy_prev = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    prot_wipe_seq #(.ERASE_CYCLES(ERASE)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .ro_lock(ro_lock), .prog_en(prog_en), .prog_addr(prog_addr),
        .prog_data(prog_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (busy && !busy_prev) begin
                rise_cnt <= rise_cnt + 1;
                rise_cyc <= cyc;
            end
            if (!busy && busy_prev) fall_cyc <= cyc;
            busy_prev <= busy;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] data, input int nbits, input bit release_cs);
        @(negedge clk);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            si = data[i];
            idle(HALF);
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        if (release_cs) begin
            cs_n = 1'b1;
            idle(2 * HALF);
        end
    endtask

    task automatic prog(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        prog_en = 1'b1; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_en = 1'b0;
    endtask

    task automatic read_byte(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(input logic [7:0] exp, input string req);
        int bad = 0;
        logic [7:0] v;
        logic [7:0] first_bad = exp;
        for (int a = 0; a < 64; a++) begin
            read_byte(6'(a), v);
            if (v !== exp) begin
                if (bad == 0) first_bad = v;
                bad++;
            end
        end
        check(bad == 0, req, "all bytes", int'(first_bad), int'(exp));
    endtask

    task automatic wait_wipe_end(input int start_rises);
        for (int i = 0; i < 3000; i++) begin
            if (rise_cnt > start_rises && !busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check_all(8'h00, "R1");
    endtask

    task automatic t_prog_needs_wipe;
        logic [7:0] v;
        prog(6'd5, 8'hFF);
        read_byte(6'd5, v);
        check(v == 8'h00, "R11", "program cannot set bits", int'(v), 8'h00);
    endtask

    task automatic t_bad_frames;
        int r0 = rise_cnt;
        send(64'h3D2A_7ECF, 32, 1'b1);            // R6 third byte wrong
        idle(40);
        check(rise_cnt == r0, "R6", "wrong byte launched", rise_cnt - r0, 0);
        send(64'h3D2A_7FC, 28, 1'b1);             // R8 mid-byte release
        idle(40);
        check(rise_cnt == r0, "R8", "short frame launched", rise_cnt - r0, 0);
        send(64'h3D2A_7F, 24, 1'b1);              // R8 three whole bytes
        idle(40);
        check(rise_cnt == r0, "R8", "three-byte frame launched", rise_cnt - r0, 0);
        send({31'd0, 32'h3D2A_7FCF, 1'b1}, 33, 1'b1); // R7 surplus bit
        idle(40);
        check(rise_cnt == r0, "R7", "33-bit frame launched", rise_cnt - r0, 0);
        send(64'hCF7F_2A3D, 32, 1'b1);            // R6 reversed order
        idle(40);
        check(rise_cnt == r0, "R6", "reversed bytes launched", rise_cnt - r0, 0);
    endtask

    task automatic t_valid_held;
        int r0 = rise_cnt;
        int waited = 0;
        send(64'h3D2A_7FCF, 32, 1'b0);
        idle(100);
        check(rise_cnt == r0 && busy == 1'b0, "R5", "started before release",
              rise_cnt - r0, 0);
        @(negedge clk);
        cs_n = 1'b1;
        while (!busy && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(busy == 1'b1 && waited <= 20, "R2", "busy rise delay", waited, 20);
        wait_wipe_end(r0);
        check(fall_cyc - rise_cyc == ERASE, "R3", "busy length",
              fall_cyc - rise_cyc, ERASE);
        check_all(8'hFF, "R4");
    endtask

    task automatic t_prog_after_wipe;
        logic [7:0] v;
        prog(6'd3, 8'h5A);
        read_byte(6'd3, v);
        check(v == 8'h5A, "R11", "program after wipe", int'(v), 8'h5A);
        prog(6'd3, 8'hF0);
        read_byte(6'd3, v);
        check(v == 8'h50, "R11", "second program ANDs", int'(v), 8'h50);
        read_byte(6'd10, v);
        check(v == 8'hFF, "R12", "untouched neighbour", int'(v), 8'hFF);
    endtask

    task automatic t_lock;
        int r0 = rise_cnt;
        logic [7:0] v;
        ro_lock = 1'b1;
        send(64'h3D2A_7FCF, 32, 1'b1);
        idle(60);
        check(rise_cnt == r0, "R10", "locked wipe started", rise_cnt - r0, 0);
        prog(6'd3, 8'h00);
        read_byte(6'd3, v);
        check(v == 8'h50, "R11", "locked program changed byte", int'(v), 8'h50);
        ro_lock = 1'b0;
    endtask

    task automatic t_busy_ignore;
        int r0 = rise_cnt;
        logic [7:0] v;
        prog(6'd7, 8'h00);
        send(64'h3D2A_7FCF, 32, 1'b1);
        for (int i = 0; i < 40 && !busy; i++) @(negedge clk);
        send(64'h3D2A_7FCF, 32, 1'b1);            // lands inside the window
        prog(6'd9, 8'h00);                        // blocked while busy
        read_byte(6'd9, v);
        check(v == 8'hFF, "R11", "program during busy", int'(v), 8'hFF);
        wait_wipe_end(r0);
        check(fall_cyc - rise_cyc == ERASE, "R9", "window extended",
              fall_cyc - rise_cyc, ERASE);
        idle(100);
        check(rise_cnt == r0 + 1, "R9", "second wipe ran", rise_cnt - r0, 1);
        read_byte(6'd7, v);
        check(v == 8'hFF, "R4", "byte 7 erased", int'(v), 8'hFF);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_prog_needs_wipe();
        t_bad_frames();
        t_valid_held();
        t_prog_after_wipe();
        t_lock();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule